// File: doc/BRIEF.md
# Register file with memory-mapped pointer addressing

This block pairs a 32 x 8 register bank with a data-space address generator. Each cycle it gives an execution unit two combinational operand reads and one synchronous write-back. The six topmost registers also serve as three 16-bit address pointers (X, Y, Z). A pointer access takes two cycles. In the first cycle the request is captured. In the second cycle the generator drives the effective address and, where the mode calls for it, writes the modified pointer back into both of its bytes at the end of that cycle.

Every effective address is classified as a register-bank hit, an I/O hit, an SRAM hit or a decode error. The register bank therefore also appears as the lowest 32 bytes of data space. A load that lands there returns the register's value on the memory read-data output. A store that lands there writes the register directly. The I/O devices and the SRAM sit outside the block and see only the address, the write strobe and the region flags. On loads they return their data on `ext_rdata`.

Top module: `regfile_ptr_agu`

## Requirements
- R1: After reset every register reads 0 on both read ports, and `ds_valid` and all four region flags are low.
- R2: Both read ports return the addressed register combinationally in the same cycle. A `wb_en` write becomes visible on the read ports in the cycle after the clock edge that performs it.
- R3: Pointer select 0 is X (registers 26 low, 27 high), 1 is Y (28/29), and 2 or 3 is Z (30/31). Mode code 0 (plain) uses the pointer as the address and leaves it unchanged.
- R4: Mode code 1 (post-increment) uses the pointer as the address. It then stores pointer+1, modulo 2^16, into both bytes, so a carry reaches the high byte.
- R5: Mode code 2 (pre-decrement) subtracts 1 from the pointer modulo 2^16, uses the result as the address and stores it back.
- R6: Mode code 3 (displacement) on Y or Z uses pointer + q, where q is the 6-bit `acc_disp` zero-extended, and leaves the pointer unchanged. On X the displacement is ignored and the access behaves as plain.
- R7: While `ds_valid` is high, exactly one region flag is set: `hit_rf` for 0x0000-0x001F, `hit_io` for 0x0020-0x005F, `hit_sram` for 0x0060-0x00DF and `dec_err` for anything higher. While `ds_valid` is low, no flag is set.
- R8: `acc_start` is accepted only when no access is in progress. `ds_valid` is then high for exactly the following cycle. A start seen during that cycle is ignored, and the pointer update takes effect at the edge that ends it.
- R9: On a register-bank hit, `mem_rdata` carries the addressed register and a store (`acc_store`=1) writes `acc_wdata` into it. For the other regions `mem_rdata` carries `ext_rdata`. `ds_write` and `ds_wdata` accompany every store.
- R10: When a memory-mapped store and a pointer update or `wb_en` write target the same register in the same edge, the store's data wins. A store into the register bank while `wb_en` is high is a flagged collision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_sel | input | 5 | Read port A register index |
| rd_b_sel | input | 5 | Read port B register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_data | output | 8 | Read port B data |
| wb_en | input | 1 | Write-back enable |
| wb_sel | input | 5 | Write-back register index |
| wb_data | input | 8 | Write-back data |
| acc_start | input | 1 | Start a pointer access |
| acc_ptr | input | 2 | Pointer select (0 X, 1 Y, 2/3 Z) |
| acc_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| acc_disp | input | 6 | Unsigned displacement q |
| acc_store | input | 1 | 1 store, 0 load |
| acc_wdata | input | 8 | Store data |
| ext_rdata | input | 8 | Load data from I/O or SRAM |
| ds_valid | output | 1 | Access cycle active |
| ds_write | output | 1 | Store strobe |
| ds_addr | output | 16 | Effective data-space address |
| ds_wdata | output | 8 | Store data toward memory |
| mem_rdata | output | 8 | Load result |
| hit_rf | output | 1 | Address falls in register bank |
| hit_io | output | 1 | Address falls in I/O range |
| hit_sram | output | 1 | Address falls in SRAM range |
| dec_err | output | 1 | Address above SRAM |

## Verification
The bench targets the range edges 0x1F/0x20, 0x5F/0x60 and 0xDF/0xE0. A wrong comparison there would raise the neighbouring region's flag. It also covers pointer wrap at 0x0000 and 0xFFFF and a post-increment from 0x00FF: a design that updated only the low byte would leave the high byte stale. A displacement request on X must not add the offset. A store through Z into Z's own low byte must leave the stored value rather than the incremented pointer, which a design with the wrong write priority would keep. A start held across both cycles must increment the pointer only once; a block that re-accepted it would step twice.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_DISP    = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        PS_X  = 2'd0,
        PS_Y  = 2'd1,
        PS_Z  = 2'd2,
        PS_Z2 = 2'd3
    } psel_e;
endpackage

// File: rtl/rfp_regbank.sv
module rfp_regbank #(
    parameter int NREG = 32,
    parameter int DW   = 8,
    parameter int AW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] ra_sel,
    input  logic [$clog2(NREG)-1:0] rb_sel,
    input  logic [$clog2(NREG)-1:0] rm_sel,
    output logic [DW-1:0]           ra,
    output logic [DW-1:0]           rb,
    output logic [DW-1:0]           rm,
    input  logic [1:0]              ptr_sel,
    output logic [AW-1:0]           ptr_val,
    input  logic                    wb_en,
    input  logic [$clog2(NREG)-1:0] wb_sel,
    input  logic [DW-1:0]           wb_data,
    input  logic                    pu_en,
    input  logic [AW-1:0]           pu_val,
    input  logic                    mm_en,
    input  logic [$clog2(NREG)-1:0] mm_sel,
    input  logic [DW-1:0]           mm_data
);
    localparam int RSW   = $clog2(NREG);
    localparam int PBASE = NREG - 6;

    logic [NREG-1:0][DW-1:0] rf_d, rf_q;
    logic [RSW-1:0]          lo_idx, hi_idx;
    logic [1:0]              pk;

    // Select 3 aliases Z
    assign pk     = (ptr_sel == 2'd3) ? 2'd2 : ptr_sel;
    assign lo_idx = RSW'(PBASE + 2 * int'(pk));
    assign hi_idx = lo_idx + RSW'(1);

    assign ra      = rf_q[ra_sel];
    assign rb      = rf_q[rb_sel];
    assign rm      = rf_q[rm_sel];
    assign ptr_val = {rf_q[hi_idx], rf_q[lo_idx]};

    // Later assignments win: mapped store over pointer update over write-back
    always_comb begin
        rf_d = rf_q;
        if (wb_en) rf_d[wb_sel] = wb_data;
        if (pu_en) begin
            rf_d[lo_idx] = pu_val[DW-1:0];
            rf_d[hi_idx] = pu_val[AW-1:DW];
        end
        if (mm_en) rf_d[mm_sel] = mm_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end
endmodule

// File: rtl/rfp_addr_gen.sv
module rfp_addr_gen #(
    parameter int AW = 16,
    parameter int QW = 6
) (
    input  logic [AW-1:0]   base,
    input  logic [1:0]      ptr_sel,
    input  rfp_pkg::amode_e mode,
    input  logic [QW-1:0]   disp,
    output logic [AW-1:0]   addr,
    output logic [AW-1:0]   new_ptr,
    output logic            upd
);
    rfp_pkg::amode_e eff;

    always_comb begin
        // Displacement exists only for Y and Z
        eff = (mode == rfp_pkg::AM_DISP && ptr_sel == 2'd0) ? rfp_pkg::AM_PLAIN : mode;
        addr    = base;
        new_ptr = base;
        upd     = 1'b0;
        case (eff)
            rfp_pkg::AM_POSTINC: begin
                new_ptr = base + AW'(1);
                upd     = 1'b1;
            end
            rfp_pkg::AM_PREDEC: begin
                new_ptr = base - AW'(1);
                addr    = base - AW'(1);
                upd     = 1'b1;
            end
            rfp_pkg::AM_DISP: addr = base + AW'(disp);
            default: ;
        endcase
    end
endmodule

// File: rtl/rfp_region_dec.sv
module rfp_region_dec #(
    parameter int AW       = 16,
    parameter int RF_END   = 'h20,
    parameter int IO_END   = 'h60,
    parameter int SRAM_END = 'hE0
) (
    input  logic [AW-1:0] addr,
    input  logic          valid,
    output logic          hit_rf,
    output logic          hit_io,
    output logic          hit_sram,
    output logic          dec_err
);
    logic below_rf, below_io, below_sram;

    assign below_rf   = addr < AW'(RF_END);
    assign below_io   = addr < AW'(IO_END);
    assign below_sram = addr < AW'(SRAM_END);

    assign hit_rf   = valid && below_rf;
    assign hit_io   = valid && !below_rf && below_io;
    assign hit_sram = valid && !below_io && below_sram;
    assign dec_err  = valid && !below_sram;
endmodule

// File: rtl/regfile_ptr_agu.sv
module regfile_ptr_agu #(
    parameter int DW       = 8,
    parameter int NREG     = 32,
    parameter int QW       = 6,
    parameter int RF_END   = 'h20,
    parameter int IO_END   = 'h60,
    parameter int SRAM_END = 'hE0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_a_sel,
    input  logic [$clog2(NREG)-1:0] rd_b_sel,
    output logic [DW-1:0]           rd_a_data,
    output logic [DW-1:0]           rd_b_data,
    input  logic                    wb_en,
    input  logic [$clog2(NREG)-1:0] wb_sel,
    input  logic [DW-1:0]           wb_data,
    input  logic                    acc_start,
    input  logic [1:0]              acc_ptr,
    input  logic [1:0]              acc_mode,
    input  logic [QW-1:0]           acc_disp,
    input  logic                    acc_store,
    input  logic [DW-1:0]           acc_wdata,
    input  logic [DW-1:0]           ext_rdata,
    output logic                    ds_valid,
    output logic                    ds_write,
    output logic [2*DW-1:0]         ds_addr,
    output logic [DW-1:0]           ds_wdata,
    output logic [DW-1:0]           mem_rdata,
    output logic                    hit_rf,
    output logic                    hit_io,
    output logic                    hit_sram,
    output logic                    dec_err
);
    localparam int AW  = 2 * DW;
    localparam int RSW = $clog2(NREG);

    typedef struct packed {
        logic            busy;
        logic [1:0]      ptr;
        rfp_pkg::amode_e mode;
        logic [QW-1:0]   disp;
        logic            store;
        logic [DW-1:0]   wdata;
    } req_t;

    req_t          req_d, req_q;
    logic [AW-1:0] ptr_now, ptr_next;
    logic          ptr_upd;
    logic [DW-1:0] rm_data;
    logic          mm_en;

    always_comb begin
        req_d      = req_q;
        req_d.busy = 1'b0;
        if (!req_q.busy && acc_start) begin
            req_d.busy  = 1'b1;
            req_d.ptr   = acc_ptr;
            req_d.mode  = rfp_pkg::amode_e'(acc_mode);
            req_d.disp  = acc_disp;
            req_d.store = acc_store;
            req_d.wdata = acc_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign ds_valid  = req_q.busy;
    assign ds_write  = req_q.busy && req_q.store;
    assign ds_wdata  = req_q.wdata;
    assign mm_en     = ds_write && hit_rf;
    assign mem_rdata = hit_rf ? rm_data : ext_rdata;

    rfp_regbank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_sel  (rd_a_sel),
        .rb_sel  (rd_b_sel),
        .rm_sel  (ds_addr[RSW-1:0]),
        .ra      (rd_a_data),
        .rb      (rd_b_data),
        .rm      (rm_data),
        .ptr_sel (req_q.ptr),
        .ptr_val (ptr_now),
        .wb_en   (wb_en),
        .wb_sel  (wb_sel),
        .wb_data (wb_data),
        .pu_en   (req_q.busy && ptr_upd),
        .pu_val  (ptr_next),
        .mm_en   (mm_en),
        .mm_sel  (ds_addr[RSW-1:0]),
        .mm_data (req_q.wdata)
    );

    rfp_addr_gen #(.AW(AW), .QW(QW)) u_agen (
        .base    (ptr_now),
        .ptr_sel (req_q.ptr),
        .mode    (req_q.mode),
        .disp    (req_q.disp),
        .addr    (ds_addr),
        .new_ptr (ptr_next),
        .upd     (ptr_upd)
    );

    rfp_region_dec #(.AW(AW), .RF_END(RF_END), .IO_END(IO_END), .SRAM_END(SRAM_END)) u_dec (
        .addr     (ds_addr),
        .valid    (req_q.busy),
        .hit_rf   (hit_rf),
        .hit_io   (hit_io),
        .hit_sram (hit_sram),
        .dec_err  (dec_err)
    );
endmodule

// File: rtl/regfile_ptr_agu_chk.sv
module regfile_ptr_agu_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_start,
    input logic ds_valid,
    input logic ds_write,
    input logic hit_rf,
    input logic hit_io,
    input logic hit_sram,
    input logic dec_err,
    input logic wb_en
);
    AST_START_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !ds_valid) |=> ds_valid); // R8
    AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |=> !ds_valid); // R8
    AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> ($countones({hit_rf, hit_io, hit_sram, dec_err}) == 1)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_valid |-> ({hit_rf, hit_io, hit_sram, dec_err} == 4'b0)); // R7
    AST_NO_WB_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_write && hit_rf) |-> !wb_en); // R10
endmodule

bind regfile_ptr_agu regfile_ptr_agu_chk u_chk (.*);

// File: tb/sim_regfile_ptr_agu.sv
module sim_regfile_ptr_agu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rd_a_sel = '0, rd_b_sel = '0, wb_sel = '0;
    logic [7:0] rd_a_data, rd_b_data, wb_data = '0;
    logic       wb_en = 1'b0, acc_start = 1'b0, acc_store = 1'b0;
    logic [1:0] acc_ptr = '0, acc_mode = '0;
    logic [5:0] acc_disp = '0;
    logic [7:0] acc_wdata = '0, ext_rdata = '0;
    logic       ds_valid, ds_write, hit_rf, hit_io, hit_sram, dec_err;
    logic [15:0] ds_addr;
    logic [7:0] ds_wdata, mem_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    regfile_ptr_agu u0 (.*);

    typedef struct packed {
        logic [1:0]  ptr;
        logic [1:0]  mode;
        logic [5:0]  q;
        logic [15:0] init;
        logic [15:0] eaddr;
        logic [15:0] eptr;
        logic [1:0]  ereg;
    } vec_t;

    // region code: 0 rf, 1 io, 2 sram, 3 error
    localparam vec_t VEC [13] = '{
        '{2'd0, 2'd0, 6'd0,  16'h0040, 16'h0040, 16'h0040, 2'd1},
        '{2'd0, 2'd1, 6'd0,  16'h005F, 16'h005F, 16'h0060, 2'd1},
        '{2'd1, 2'd2, 6'd0,  16'h0060, 16'h005F, 16'h005F, 2'd1},
        '{2'd2, 2'd1, 6'd0,  16'h00DF, 16'h00DF, 16'h00E0, 2'd2},
        '{2'd2, 2'd2, 6'd0,  16'h00E0, 16'h00DF, 16'h00DF, 2'd2},
        '{2'd1, 2'd3, 6'd63, 16'h00A0, 16'h00DF, 16'h00A0, 2'd2},
        '{2'd2, 2'd3, 6'd63, 16'h00A1, 16'h00E0, 16'h00A1, 2'd3},
        '{2'd0, 2'd2, 6'd0,  16'h0000, 16'hFFFF, 16'hFFFF, 2'd3},
        '{2'd1, 2'd1, 6'd0,  16'hFFFF, 16'hFFFF, 16'h0000, 2'd3},
        '{2'd0, 2'd3, 6'd5,  16'h0030, 16'h0030, 16'h0030, 2'd1},
        '{2'd2, 2'd0, 6'd0,  16'h0012, 16'h0012, 16'h0012, 2'd0},
        '{2'd1, 2'd1, 6'd0,  16'h001F, 16'h001F, 16'h0020, 2'd0},
        '{2'd0, 2'd1, 6'd0,  16'h00FF, 16'h00FF, 16'h0100, 2'd3}
    };

    // values captured in the access cycle
    logic [15:0] s_addr;
    logic [7:0]  s_rdata, s_wdata;
    logic        s_valid, s_write;
    logic [2:0]  s_reg;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] region_code();
        if (hit_rf)   return 3'd0;
        if (hit_io)   return 3'd1;
        if (hit_sram) return 3'd2;
        if (dec_err)  return 3'd3;
        return 3'd7;
    endfunction

    task automatic wb(input logic [4:0] sel, input logic [7:0] d);
        @(negedge clk);
        wb_en = 1'b1; wb_sel = sel; wb_data = d;
        @(negedge clk);
        wb_en = 1'b0;
    endtask

    task automatic set_ptr(input logic [1:0] p, input logic [15:0] v);
        wb(5'd26 + {2'b0, p, 1'b0}, v[7:0]);
        wb(5'd27 + {2'b0, p, 1'b0}, v[15:8]);
    endtask

    task automatic read_pair(input logic [4:0] lo, output logic [15:0] v);
        rd_a_sel = lo; rd_b_sel = lo + 5'd1;
        #1;
        v = {rd_b_data, rd_a_data};
    endtask

    task automatic access(input logic [1:0] p, input logic [1:0] m, input logic [5:0] q,
                          input logic st, input logic [7:0] wd, input bit hold);
        @(negedge clk);
        acc_start = 1'b1; acc_ptr = p; acc_mode = m; acc_disp = q;
        acc_store = st; acc_wdata = wd;
        @(negedge clk);
        if (!hold) acc_start = 1'b0;
        #2;
        s_valid = ds_valid; s_write = ds_write; s_addr = ds_addr;
        s_rdata = mem_rdata; s_wdata = ds_wdata; s_reg = region_code();
        @(negedge clk);
        acc_start = 1'b0;
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd1: return "R4";
            2'd2: return "R5";
            2'd3: return "R6";
            default: return "R3";
        endcase
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_a_sel = 5'd5; rd_b_sel = 5'd31; #1;
        check("R1 port A", rd_a_data, 8'h00);
        check("R1 port B", rd_b_data, 8'h00);
        check("R1 valid", ds_valid, 1'b0);
        check("R1 flags", {hit_rf, hit_io, hit_sram, dec_err}, 4'b0);

        // R2: two reads in one cycle after write-back
        wb(5'd3, 8'h3C);
        wb(5'd17, 8'hC3);
        rd_a_sel = 5'd3; rd_b_sel = 5'd17; #1;
        check("R2 port A", rd_a_data, 8'h3C);
        check("R2 port B", rd_b_data, 8'hC3);

        // Table of pointer accesses
        for (int i = 0; i < 13; i++) begin
            set_ptr(VEC[i].ptr, VEC[i].init);
            access(VEC[i].ptr, VEC[i].mode, VEC[i].q, 1'b0, 8'h00, 1'b0);
            check("R8 valid", s_valid, 1'b1);
            check({mode_tag(VEC[i].mode), " addr"}, s_addr, VEC[i].eaddr);
            check("R7 region", s_reg, {1'b0, VEC[i].ereg});
            read_pair(5'd26 + {2'b0, VEC[i].ptr, 1'b0}, pv);
            check({mode_tag(VEC[i].mode), " pointer"}, pv, VEC[i].eptr);
        end

        // R9: store into register bank through Z
        set_ptr(2'd2, 16'h0005);
        access(2'd2, 2'd0, 6'd0, 1'b1, 8'hA5, 1'b0);
        check("R9 write strobe", s_write, 1'b1);
        check("R9 store data", s_wdata, 8'hA5);
        check("R9 rf region", s_reg, 3'd0);
        rd_a_sel = 5'd5; #1;
        check("R9 stored reg", rd_a_data, 8'hA5);

        // R9: load from register bank through Y
        wb(5'd9, 8'h5A);
        set_ptr(2'd1, 16'h0009);
        ext_rdata = 8'h99;
        access(2'd1, 2'd0, 6'd0, 1'b0, 8'h00, 1'b0);
        check("R9 load rf", s_rdata, 8'h5A);

        // R9: load from I/O returns external data
        set_ptr(2'd0, 16'h0025);
        access(2'd0, 2'd0, 6'd0, 1'b0, 8'h00, 1'b0);
        check("R9 load io", s_rdata, 8'h99);
        check("R7 io region", s_reg, 3'd1);

        // R10: store into Z low byte wins over Z post-increment
        set_ptr(2'd2, 16'h001E);
        access(2'd2, 2'd1, 6'd0, 1'b1, 8'h77, 1'b0);
        read_pair(5'd30, pv);
        check("R10 store priority", pv, 16'h0077);

        // R8: start held across access cycle is taken once
        set_ptr(2'd1, 16'h0070);
        access(2'd1, 2'd1, 6'd0, 1'b0, 8'h00, 1'b1);
        #2;
        check("R8 no second access", ds_valid, 1'b0);
        read_pair(5'd28, pv);
        check("R8 single increment", pv, 16'h0071);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule